// File: doc/BRIEF.md
# Latched-Address Fuse Memory

This block models a 2048-word by 8-bit memory whose cells can be written once. A cell starts at 0 and can be set to 1, but never cleared. All inputs are sampled with the system clock. The chip-enable and output-enable inputs are active low and act through their falling edges, which the block finds by comparing each input with its value on the previous clock.

When chip enable is seen going low, the address on the bus is captured. It then stays fixed for the whole access, whatever the address bus does next. A later falling edge on output enable drives the stored word onto the data output and raises a drive flag. Together the data output and the drive flag stand in for a three-state bus. Setting either enable high removes the data.

If program enable is low when chip enable falls, the block performs a burn instead of a read. The supplied byte is ORed into the addressed word. A request to turn a stored 1 back into 0 is ignored and sets a sticky flag. Minimum low and high times for chip enable are parameters, and breaking either one sets a sticky timing flag.

The sequencer has four states:
- `ST_IDLE`: chip enable is high.
- `ST_HOLD`: the address is latched and the output is off.
- `ST_DRIVE`: the output is on.
- `ST_BURN`: a program cycle is in progress.

Its transitions are:
- T_ENTER: `ST_IDLE`→`ST_HOLD`, on a chip-enable fall with program enable high.
- T_BURN: `ST_IDLE`→`ST_BURN`, on a chip-enable fall with program enable low.
- T_GATE: `ST_HOLD`→`ST_DRIVE`, on an output-enable fall with program enable high.
- T_UNGATE: `ST_DRIVE`→`ST_HOLD`, when output enable is high or program enable is low.
- T_RELEASE: from any state to `ST_IDLE`, when chip enable is high.

Top module: `latched_otp_mem`

## Requirements
- R1: After synchronous reset, `bus_drive` is 0, `bus_data` is 0, and both `strobe_fault` and `clear_refused` are 0.
- R2: The address is captured on the clock where `ce_n` is seen going from 1 to 0. Changes on `addr` after that clock do not change the word read in that access.
- R3: `bus_drive` is 1 in the cycle after the clock where `oe_n` is seen falling, given that `ce_n` is low, the address is latched and `pgm_n` is 1. `bus_data` then equals the stored word at the latched address.
- R4: `bus_drive` drops to 0 (and `bus_data` to 0) on the clock where `oe_n` or `ce_n` is sampled high.
- R5: `bus_data` stays constant for as long as `bus_drive` stays 1.
- R6: A word that has never been programmed reads as 8'h00.
- R7: A burn happens on the clock where `ce_n` is seen falling while `pgm_n` is 0. It makes the stored word equal to the old word OR `pgm_data`, and a stored 1 is never lost.
- R8: A burn where `pgm_data` has a 0 at a bit that is already 1 sets `clear_refused`. The flag stays set until reset, and the stored word keeps that 1.
- R9: While `pgm_n` is 0, `bus_drive` stays 0 even if `oe_n` falls.
- R10: `strobe_fault` is set, and stays set until reset, under either of two conditions. One is `ce_n` being low on fewer than MIN_LOW sampled clocks before it rises. The other is `ce_n` being high on fewer than MIN_HIGH sampled clocks before it falls. Accesses that respect both limits leave it at 0.
- R11: Reset does not change any stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 11 | Word address; bits 10..4 pick the matrix row, bits 3..0 the column in each bit's group |
| ce_n | input | 1 | Chip enable, active low; its falling edge latches the address |
| oe_n | input | 1 | Output enable, active low; its falling edge starts driving |
| pgm_n | input | 1 | Program enable, active low |
| pgm_data | input | 8 | Byte ORed into the word during a burn |
| bus_data | output | 8 | Read data, 0 when not driving |
| bus_drive | output | 1 | Bus-drive flag (three-state enable) |
| strobe_fault | output | 1 | Sticky chip-enable timing violation |
| clear_refused | output | 1 | Sticky flag for a refused 1-to-0 request |

## Verification
Suppose the latched address or the row and column decode is wrong. The bus then shows a word from another location, one cycle after output enable falls. An exhaustive read sweep with a per-address pattern exposes this at the first address that differs. Suppose instead the sequencer is in the wrong state. Then `bus_drive` either comes up during a burn or fails to drop on the clock where an enable is sampled high, which is visible one cycle after the stimulus. A faulty burn path can clear bits or set the wrong ones. That appears on the next read of that word, and a mis-set sticky flag appears on the very next cycle.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_DRIVE = 2'd2,
        ST_BURN  = 2'd3
    } otp_state_e;

endpackage

// File: rtl/otp_strobe_timer.sv
module otp_strobe_timer #(
    parameter int MIN_LOW  = 2,
    parameter int MIN_HIGH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic oe_n,
    output logic ce_fall,
    output logic ce_rise,
    output logic oe_fall,
    output logic fault
);
    localparam int LIM   = (MIN_LOW > MIN_HIGH) ? MIN_LOW : MIN_HIGH;
    localparam int CNT_W = $clog2(LIM + 1);
    localparam logic [CNT_W-1:0] LIM_C  = CNT_W'(LIM);
    localparam logic [CNT_W-1:0] LOW_C  = CNT_W'(MIN_LOW);
    localparam logic [CNT_W-1:0] HIGH_C = CNT_W'(MIN_HIGH);

    logic             ce_prev, oe_prev;
    logic [CNT_W-1:0] low_cnt, high_cnt;
    logic             fault_q;

    assign ce_fall = ce_prev & ~ce_n;
    assign ce_rise = ~ce_prev & ce_n;
    assign oe_fall = oe_prev & ~oe_n;
    assign fault   = fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_prev <= 1'b1;
            oe_prev <= 1'b1;
        end else begin
            ce_prev <= ce_n;
            oe_prev <= oe_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= '0;
            high_cnt <= LIM_C;
        end else begin
            if (ce_fall)
                low_cnt <= CNT_W'(1);
            else if (!ce_n && low_cnt < LIM_C)
                low_cnt <= low_cnt + CNT_W'(1);
            if (ce_rise)
                high_cnt <= CNT_W'(1);
            else if (ce_n && high_cnt < LIM_C)
                high_cnt <= high_cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            fault_q <= 1'b0;
        else if ((ce_rise && low_cnt < LOW_C) || (ce_fall && high_cnt < HIGH_C))
            fault_q <= 1'b1;
    end

    // R10: a timing fault is kept until reset
    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        fault_q |=> fault_q);

endmodule

// File: rtl/otp_fuse_matrix.sv
module otp_fuse_matrix #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int COL_W  = 4
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_conflict
);
    localparam int ROW_W = ADDR_W - COL_W;
    localparam int ROWS  = 1 << ROW_W;
    localparam int GRP   = 1 << COL_W;
    localparam int LINE  = DATA_W * GRP;

    logic [LINE-1:0] fuse_q [ROWS];

    initial begin
        for (int r = 0; r < ROWS; r++)
            fuse_q[r] = '0;
    end

    logic [ROW_W-1:0]  rd_row, wr_row;
    logic [COL_W-1:0]  rd_col, wr_col;
    logic [LINE-1:0]   rd_line, wr_line, burn_line;
    logic [DATA_W-1:0] wr_old;

    assign rd_row  = rd_addr[ADDR_W-1:COL_W];
    assign rd_col  = rd_addr[COL_W-1:0];
    assign wr_row  = wr_addr[ADDR_W-1:COL_W];
    assign wr_col  = wr_addr[COL_W-1:0];
    assign rd_line = fuse_q[rd_row];
    assign wr_line = fuse_q[wr_row];

    for (genvar j = 0; j < DATA_W; j++) begin : g_bit
        logic [GRP-1:0] rd_grp, wr_grp;
        assign rd_grp     = rd_line[j*GRP +: GRP];
        assign wr_grp     = wr_line[j*GRP +: GRP];
        assign rd_data[j] = rd_grp[rd_col];
        assign wr_old[j]  = wr_grp[wr_col];
    end

    assign wr_conflict = |(wr_old & ~wr_data);

    always_comb begin
        burn_line = wr_line;
        for (int j = 0; j < DATA_W; j++) begin
            if (wr_data[j])
                burn_line[j*GRP +: GRP] = burn_line[j*GRP +: GRP] |
                    ({{(GRP-1){1'b0}}, 1'b1} << wr_col);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            fuse_q[wr_row] <= burn_line;
    end

endmodule

// File: rtl/latched_otp_mem.sv
module latched_otp_mem #(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int COL_W    = 4,
    parameter int MIN_LOW  = 2,
    parameter int MIN_HIGH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic [DATA_W-1:0] pgm_data,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_drive,
    output logic              strobe_fault,
    output logic              clear_refused
);
    import otp_pkg::*;

    otp_state_e        state_q, state_d;
    logic              ce_fall, ce_rise, oe_fall;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] rd_word;
    logic              wr_en, wr_conflict;
    logic              refused_q;

    otp_strobe_timer #(.MIN_LOW(MIN_LOW), .MIN_HIGH(MIN_HIGH)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .ce_fall (ce_fall),
        .ce_rise (ce_rise),
        .oe_fall (oe_fall),
        .fault   (strobe_fault)
    );

    assign wr_en = !rst && state_q == ST_IDLE && ce_fall && !pgm_n;

    otp_fuse_matrix #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) u_matrix (
        .clk         (clk),
        .rd_addr     (lat_addr),
        .wr_en       (wr_en),
        .wr_addr     (addr),
        .wr_data     (pgm_data),
        .rd_data     (rd_word),
        .wr_conflict (wr_conflict)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ce_fall) state_d = pgm_n ? ST_HOLD : ST_BURN;   // T_ENTER / T_BURN
            end
            ST_HOLD: begin
                if (ce_n)                    state_d = ST_IDLE;     // T_RELEASE
                else if (oe_fall && pgm_n)   state_d = ST_DRIVE;    // T_GATE
            end
            ST_DRIVE: begin
                if (ce_n)                    state_d = ST_IDLE;     // T_RELEASE
                else if (oe_n || !pgm_n)     state_d = ST_HOLD;     // T_UNGATE
            end
            ST_BURN: begin
                if (ce_n)                    state_d = ST_IDLE;     // T_RELEASE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs, latch and sticky flag
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_addr  <= '0;
            bus_data  <= '0;
            bus_drive <= 1'b0;
            refused_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && ce_fall)
                lat_addr <= addr;
            bus_drive <= (state_d == ST_DRIVE);
            if (state_d != ST_DRIVE)
                bus_data <= '0;
            else if (state_q != ST_DRIVE)
                bus_data <= rd_word;
            if (wr_en && wr_conflict)
                refused_q <= 1'b1;
        end
    end

    assign clear_refused = refused_q;

    // R3: driving begins only after output enable was sampled low with chip enable low and programming off
    p_gate_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_drive) |-> $past(!oe_n && !ce_n && pgm_n));
    // R4: a high enable removes the drive on the following edge
    p_ce_release_r4: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> !bus_drive);
    p_oe_release_r4: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> !bus_drive);
    // R5: the driven word does not change while driving
    p_data_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_drive && $past(bus_drive)) |-> $stable(bus_data));
    // R9: no driving during programming
    p_no_drive_burn_r9: assert property (@(posedge clk) disable iff (rst)
        !pgm_n |=> !bus_drive);
    // R8: refused-clear flag is kept until reset
    p_refused_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        refused_q |=> refused_q);

endmodule

// File: tb/latched_otp_mem_tb.sv
`timescale 1ns/1ps
module latched_otp_mem_tb;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
    logic [DW-1:0] pgm_data = '0;
    logic [DW-1:0] bus_data;
    logic          bus_drive, strobe_fault, clear_refused;

    int n_cmp = 0;
    int n_bad = 0;
    logic [DW-1:0] model [WORDS];
    logic          exp_refused;

    always #2.5 clk = ~clk;

    latched_otp_mem u_dut (
        .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .pgm_n(pgm_n), .pgm_data(pgm_data), .bus_data(bus_data),
        .bus_drive(bus_drive), .strobe_fault(strobe_fault),
        .clear_refused(clear_refused)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat1(input int a);
        return DW'(a * 29 + 3);
    endfunction

    function automatic logic [DW-1:0] pat2(input int a);
        return DW'(a * 7 + 1);
    endfunction

    task automatic idle_high(input int n);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 drive", bus_drive, 0);
        check("R1 data", bus_data, 0);
        check("R1 fault", strobe_fault, 0);
        check("R1 refused", clear_refused, 0);
    endtask

    task automatic read_word(input int a, input string req);
        idle_high(3);
        ce_n = 1'b0; addr = AW'(a);
        @(negedge clk);
        addr = ~AW'(a);              // R2: changed after latch
        oe_n = 1'b0;
        @(negedge clk);
        check({req, " drive"}, bus_drive, 1);
        check({req, " data"}, bus_data, model[a]);
        @(negedge clk);
        check("R5 stable", bus_data, model[a]);
        oe_n = 1'b1;
        @(negedge clk);
        check("R4 drop", bus_drive, 0);
    endtask

    task automatic burn_word(input int a, input logic [DW-1:0] d);
        idle_high(3);
        ce_n = 1'b0; pgm_n = 1'b0; addr = AW'(a); pgm_data = d;
        @(negedge clk);
        oe_n = 1'b0;
        @(negedge clk);
        check("R9 no drive", bus_drive, 0);
        if ((model[a] & ~d) != 0) exp_refused = 1'b1;
        model[a] = model[a] | d;
    endtask

    initial begin
        for (int a = 0; a < WORDS; a++) model[a] = '0;
        exp_refused = 1'b0;
        do_reset();

        for (int a = 0; a < WORDS; a++) read_word(a, "R6");

        for (int a = 0; a < WORDS; a++) burn_word(a, pat1(a));
        idle_high(3);
        check("R8 no refusal on blank", clear_refused, 0);
        for (int a = 0; a < WORDS; a++) read_word(a, "R7");

        for (int a = 0; a < 64; a++) begin
            burn_word(a, pat2(a));
            idle_high(1);
            check("R8 flag", clear_refused, exp_refused);
        end
        for (int a = 0; a < 64; a++) read_word(a, "R7 or");
        check("R10 no false fault", strobe_fault, 0);

        do_reset();
        for (int a = 0; a < 256; a++) read_word(a, "R11");

        // R10: chip enable low too briefly
        idle_high(3);
        ce_n = 1'b0; addr = '0;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        check("R10 short low", strobe_fault, 1);
        idle_high(2);
        check("R10 sticky", strobe_fault, 1);

        // R10: chip enable high too briefly
        do_reset();
        idle_high(3);
        ce_n = 1'b0;
        repeat (3) @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        check("R10 before short high", strobe_fault, 0);
        ce_n = 1'b0;
        @(negedge clk);
        check("R10 short high", strobe_fault, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule